// File: doc/BRIEF.md
# Serial-Unlock Timekeeping Register Access Sequencer

This block watches the chip-enabled cycles of a byte-wide memory bus and opens a hidden path to a bank of eight 8-bit timekeeping registers. The bus is sampled as one synchronous cycle strobe per access, with a write flag and the level of data bit 0. Every access normally reaches the memory. A read arms a key comparison. Each write after it compares data bit 0 with the next bit of a fixed 64-bit key. When all 64 bits have matched, the next 64 chip-enabled cycles become a serial transfer window. During that window the memory select is held off. Each read cycle drives one register bit out on the serial data line, and each write cycle captures one bit.

Read data in the window comes from a snapshot of all eight registers taken at the moment of unlock, so the output stays coherent while the live registers may change. Written bits are gathered a byte at a time. A byte is committed only when all eight cycles of its group were writes. A reset pin can cut a transfer short when a control bit in the register bank allows it. A power-fail input blocks the bus completely.

Top module: `rtc_unlock_seq`

## Requirements
- R1: After reset, no transfer is open and the recognizer is not armed. Registers 0-3 and 5-7 are 8'h00, and register 4 is 8'h30: bit 4 is the reset-pin enable (1 means the pin is ignored) and bit 5 is the oscillator-stop bit.
- R2: A read followed by 64 writes opens the transfer window when data bit 0 of write i equals key bit i. The key is the byte sequence C5, 3A, A3, 5C, C5, 3A, A3, 5C, each byte sent least-significant bit first. The window opens on the clock edge of the 64th matching write.
- R3: A read at any point before the key completes re-arms recognition with the pointer back at key bit 0.
- R4: A mismatching write freezes recognition: later writes cannot unlock until a read re-arms it. Writes that come before any read, or after a completed window, are also ignored for recognition.
- R5: Outside the window, mem_en_o equals cyc_i whenever power is good, including during the key writes. During the 64 window cycles mem_en_o is 0.
- R6: On a read in window cycle n (0..63), rd_bit_o shows bit n%8 of register n/8, taken from the snapshot made at unlock. At all other times rd_bit_o is 0.
- R7: A write in window cycle n supplies bit n%8 of register n/8. A register is updated as a whole at the end of its 8-cycle group, and only if all eight cycles of that group were writes. Otherwise the register is left unchanged.
- R8: While the window is open, power is good and register 4 bit 4 is 0, a low rst_pin_ni at a clock edge closes the window. The cycle at that edge is not processed, and registers already committed keep their values. When bit 4 is 1, the pin has no effect.
- R9: While pwr_fail_i is 1, mem_en_o and rd_bit_o are 0 and no cycle changes the key pointer, the window position or any register.
- R10: A clock with cyc_i low neither advances nor resets any pointer. After the 64th window cycle the block returns to memory-mapped operation and needs a new read plus the full key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_i | input | 1 | One chip-enabled bus cycle completes at this clock edge |
| we_i | input | 1 | The cycle is a write (1) or a read (0) |
| d0_i | input | 1 | Level of data bit 0 during the cycle |
| rst_pin_ni | input | 1 | Active-low transfer-abort pin |
| pwr_fail_i | input | 1 | Supply out of tolerance; blocks all access |
| mem_en_o | output | 1 | Memory select gate for the current cycle |
| rd_bit_o | output | 1 | Serial register bit for a window read cycle |

## Verification
The hardest states to reach are a transfer cut short by the reset pin partway through a byte group, and a group that mixes reads and writes. In both cases the register contents can only be seen through a later full unlock and 64-cycle readback. The bench first writes register 4 through a complete window to clear its pin-enable bit. It then opens a second window, aborts it twelve cycles in, and reads everything back through a third window. Key sequences are also laced with idle cycles, power-fail cycles, mid-key reads and a single wrong bit. This shows that only an unbroken matching run opens the window.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;
  localparam int KEY_BITS = 64;
  localparam logic [31:0] KEY_WORD = 32'h5CA3_3AC5;

  function automatic logic [KEY_BITS-1:0] unlock_key();
    logic [KEY_BITS-1:0] k;
    for (int i = 0; i < KEY_BITS; i++) k[i] = KEY_WORD[i % 32];
    return k;
  endfunction

  typedef enum logic [1:0] {
    MATCH_IDLE   = 2'd0,
    MATCH_ARMED  = 2'd1,
    MATCH_FROZEN = 2'd2
  } match_st_e;
endpackage

// File: rtl/rtc_key_match.sv
module rtc_key_match
  import rtc_seq_pkg::*;
#(
  parameter int                  NBITS = 64,
  parameter logic [NBITS-1:0]    KEY   = '0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_i,
  input  logic                      wr_i,
  input  logic                      d0_i,
  output logic                      unlock_o,
  output logic [$clog2(NBITS)-1:0]  ptr_o,
  output logic                      frozen_o
);
  localparam int PW = $clog2(NBITS);
  localparam logic [PW-1:0] LAST = PW'(NBITS - 1);

  match_st_e     st_q;
  logic [PW-1:0] ptr_q;
  logic          hit;

  assign hit      = (d0_i == KEY[ptr_q]);
  assign unlock_o = wr_i && (st_q == MATCH_ARMED) && hit && (ptr_q == LAST);
  assign ptr_o    = ptr_q;
  assign frozen_o = (st_q == MATCH_FROZEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= MATCH_IDLE;
      ptr_q <= '0;
    end else if (rd_i) begin
      st_q  <= MATCH_ARMED;
      ptr_q <= '0;
    end else if (wr_i && st_q == MATCH_ARMED) begin
      if (!hit) begin
        st_q <= MATCH_FROZEN;
      end else if (ptr_q == LAST) begin
        st_q  <= MATCH_IDLE;
        ptr_q <= '0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_xfer_ctrl.sv
module rtc_xfer_ctrl #(
  parameter int XFER_BITS = 64,
  parameter int REG_W     = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          abort_i,
  input  logic                          rd_i,
  input  logic                          wr_i,
  input  logic                          d0_i,
  output logic                          busy_o,
  output logic [$clog2(XFER_BITS)-1:0]  idx_o,
  output logic                          commit_o,
  output logic [REG_W-1:0]              commit_data_o
);
  localparam int IW = $clog2(XFER_BITS);
  localparam int BW = $clog2(REG_W);
  localparam logic [IW-1:0] LAST = IW'(XFER_BITS - 1);

  logic             busy_q;
  logic [IW-1:0]    cnt_q;
  logic [REG_W-1:0] sh_q;
  logic             grp_ok_q;
  logic             step, grp_first, grp_last, grp_ok_now;

  assign step       = busy_q && (rd_i || wr_i) && !abort_i;
  assign grp_first  = (cnt_q[BW-1:0] == '0);
  assign grp_last   = (cnt_q[BW-1:0] == '1);
  assign grp_ok_now = grp_first ? 1'b1 : grp_ok_q;

  assign commit_o      = step && wr_i && grp_last && grp_ok_now;
  assign commit_data_o = {d0_i, sh_q[REG_W-1:1]};
  assign busy_o        = busy_q;
  assign idx_o         = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      grp_ok_q <= 1'b1;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      cnt_q    <= '0;
      grp_ok_q <= 1'b1;
    end else if (step) begin
      cnt_q    <= cnt_q + 1'b1;
      grp_ok_q <= grp_last ? 1'b1 : (grp_ok_now && wr_i);
      if (wr_i) sh_q <= {d0_i, sh_q[REG_W-1:1]};
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int               NUM_REGS = 8,
  parameter int               REG_W    = 8,
  parameter int               RST_REG  = 4,
  parameter int               RST_BIT  = 4,
  parameter logic [REG_W-1:0] RST_VAL  = 8'h30
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 commit_i,
  input  logic [$clog2(NUM_REGS*REG_W)-1:0]    idx_i,
  input  logic [REG_W-1:0]                     commit_data_i,
  input  logic                                 snap_i,
  output logic                                 snap_bit_o,
  output logic                                 rst_en_o
);
  localparam int IW = $clog2(NUM_REGS * REG_W);
  localparam int BW = $clog2(REG_W);

  logic [REG_W-1:0] regs_q [NUM_REGS];
  logic [REG_W-1:0] snap_q [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam logic [REG_W-1:0] INIT = (k == RST_REG) ? RST_VAL : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[k] <= INIT;
        snap_q[k] <= '0;
      end else begin
        if (commit_i && (idx_i[IW-1:BW] == (IW-BW)'(k))) regs_q[k] <= commit_data_i;
        if (snap_i) snap_q[k] <= regs_q[k];
      end
    end
  end

  assign snap_bit_o = snap_q[idx_i[IW-1:BW]][idx_i[BW-1:0]];
  assign rst_en_o   = ~regs_q[RST_REG][RST_BIT];
endmodule

// File: rtl/rtc_unlock_seq.sv
module rtc_unlock_seq
  import rtc_seq_pkg::*;
#(
  parameter int               NUM_REGS = 8,
  parameter int               REG_W    = 8,
  parameter int               RST_REG  = 4,
  parameter int               RST_BIT  = 4,
  parameter logic [REG_W-1:0] RST_VAL  = 8'h30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_i,
  input  logic we_i,
  input  logic d0_i,
  input  logic rst_pin_ni,
  input  logic pwr_fail_i,
  output logic mem_en_o,
  output logic rd_bit_o
);
  localparam int XFER_BITS = NUM_REGS * REG_W;
  localparam int IW        = $clog2(XFER_BITS);
  localparam int PW        = $clog2(KEY_BITS);

  logic             cyc_ok, rd_cyc, wr_cyc;
  logic             unlock, xfer_busy, key_frozen, abort;
  logic [PW-1:0]    key_ptr;
  logic [IW-1:0]    xfer_idx;
  logic             commit, snap_bit, pin_en;
  logic [REG_W-1:0] commit_data;

  assign cyc_ok = cyc_i && !pwr_fail_i;
  assign rd_cyc = cyc_ok && !we_i;
  assign wr_cyc = cyc_ok && we_i;
  assign abort  = xfer_busy && !pwr_fail_i && !rst_pin_ni && pin_en;

  rtc_key_match #(.NBITS(KEY_BITS), .KEY(unlock_key())) u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_cyc && !xfer_busy),
    .wr_i     (wr_cyc && !xfer_busy),
    .d0_i     (d0_i),
    .unlock_o (unlock),
    .ptr_o    (key_ptr),
    .frozen_o (key_frozen)
  );

  rtc_xfer_ctrl #(.XFER_BITS(XFER_BITS), .REG_W(REG_W)) u_xfer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (unlock),
    .abort_i       (abort),
    .rd_i          (rd_cyc),
    .wr_i          (wr_cyc),
    .d0_i          (d0_i),
    .busy_o        (xfer_busy),
    .idx_o         (xfer_idx),
    .commit_o      (commit),
    .commit_data_o (commit_data)
  );

  rtc_regfile #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .RST_REG(RST_REG),
    .RST_BIT(RST_BIT), .RST_VAL(RST_VAL)
  ) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .commit_i      (commit),
    .idx_i         (xfer_idx),
    .commit_data_i (commit_data),
    .snap_i        (unlock),
    .snap_bit_o    (snap_bit),
    .rst_en_o      (pin_en)
  );

  assign mem_en_o = cyc_ok && !xfer_busy;
  assign rd_bit_o = rd_cyc && xfer_busy && snap_bit;
endmodule

// File: rtl/rtc_unlock_seq_chk.sv
module rtc_unlock_seq_chk #(
  parameter int PW = 6,
  parameter int IW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cyc_i,
  input logic          we_i,
  input logic          pwr_fail_i,
  input logic          mem_en_o,
  input logic          rd_bit_o,
  input logic          unlock,
  input logic          xfer_busy,
  input logic          key_frozen,
  input logic [PW-1:0] key_ptr,
  input logic [IW-1:0] xfer_idx
);
  assert_unlock_gates_mem_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock |=> !mem_en_o);

  assert_read_rearms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && !we_i && !pwr_fail_i && !xfer_busy) |=> (key_ptr == '0) && !key_frozen);

  assert_frozen_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_frozen && !(cyc_i && !we_i && !pwr_fail_i)) |=> key_frozen && $stable(key_ptr));

  assert_pf_blocks_out_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |-> !mem_en_o && !rd_bit_o);

  assert_pf_holds_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> $stable(key_ptr) && $stable(xfer_idx));

  assert_rd_only_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_bit_o |-> xfer_busy && cyc_i && !we_i);

  assert_idle_keeps_ptr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_i |=> $stable(key_ptr));
endmodule

bind rtc_unlock_seq rtc_unlock_seq_chk #(.PW(PW), .IW(IW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cyc_i      (cyc_i),
  .we_i       (we_i),
  .pwr_fail_i (pwr_fail_i),
  .mem_en_o   (mem_en_o),
  .rd_bit_o   (rd_bit_o),
  .unlock     (unlock),
  .xfer_busy  (xfer_busy),
  .key_frozen (key_frozen),
  .key_ptr    (key_ptr),
  .xfer_idx   (xfer_idx)
);

// File: tb/test_rtc_unlock_seq.sv
module test_rtc_unlock_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 1'b0, we = 1'b0, d0 = 1'b0, pin = 1'b1, pf = 1'b0;
  logic mem_en_o, rd_bit_o;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  rtc_unlock_seq i_rtc_unlock_seq (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .we_i(we), .d0_i(d0),
    .rst_pin_ni(pin), .pwr_fail_i(pf), .mem_en_o(mem_en_o), .rd_bit_o(rd_bit_o)
  );

  // behavioural reference
  logic [7:0] m_regs [8];
  logic [7:0] m_snap [8];
  int  m_ptr, m_cnt;
  bit  m_armed, m_frozen, m_busy;
  int  m_grp[$];

  function automatic logic key_bit(int i);
    logic [7:0] kb [4];
    kb = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};
    return kb[(i / 8) % 4][i % 8];
  endfunction

  function automatic void model_reset();
    foreach (m_regs[k]) begin m_regs[k] = 8'h00; m_snap[k] = 8'h00; end
    m_regs[4] = 8'h30;
    m_ptr = 0; m_cnt = 0; m_armed = 0; m_frozen = 0; m_busy = 0;
    m_grp.delete();
  endfunction

  function automatic void model_step(logic c, logic w, logic d, logic p, logic f);
    if (m_busy && !f && !p && !m_regs[4][4]) begin
      m_busy = 0; m_cnt = 0; m_grp.delete();
    end else if (c && !f) begin
      if (m_busy) begin
        m_grp.push_back(w ? int'(d) : 2);
        if (m_cnt % 8 == 7) begin
          bit ok = (m_grp.size() == 8);
          foreach (m_grp[j]) if (m_grp[j] == 2) ok = 0;
          if (ok) foreach (m_grp[j]) m_regs[m_cnt / 8][j] = m_grp[j][0];
          m_grp.delete();
        end
        m_cnt++;
        if (m_cnt == 64) begin m_busy = 0; m_cnt = 0; end
      end else if (!w) begin
        m_armed = 1; m_frozen = 0; m_ptr = 0;
      end else if (m_armed && !m_frozen) begin
        if (d == key_bit(m_ptr)) begin
          m_ptr++;
          if (m_ptr == 64) begin
            m_busy = 1; m_cnt = 0; m_armed = 0; m_ptr = 0;
            m_grp.delete();
            foreach (m_snap[k]) m_snap[k] = m_regs[k];
          end
        end else m_frozen = 1;
      end
    end
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic bus(logic c, logic w, logic d, logic p = 1'b1, logic f = 1'b0);
    logic e_mem, e_rd;
    @(negedge clk);
    cyc = c; we = w; d0 = d; pin = p; pf = f;
    #1;
    e_mem = c && !f && !m_busy;
    e_rd  = c && !f && !w && m_busy && m_snap[m_cnt / 8][m_cnt % 8];
    check(cur_req, mem_en_o, e_mem, "mem_en_o");
    check(cur_req, rd_bit_o, e_rd, "rd_bit_o");
    @(posedge clk);
    model_step(c, w, d, p, f);
  endtask

  task automatic rd();               bus(1'b1, 1'b0, 1'b0); endtask
  task automatic wr(logic d);        bus(1'b1, 1'b1, d);    endtask
  task automatic unlock();
    rd();
    for (int i = 0; i < 64; i++) wr(key_bit(i));
  endtask
  task automatic xfer_read();
    for (int i = 0; i < 64; i++) rd();
  endtask
  task automatic xfer_write(logic [63:0] v);
    for (int i = 0; i < 64; i++) wr(v[i]);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state: memory mapped, register 4 = 0x30
    cur_req = "R1";
    bus(1'b0, 1'b0, 1'b0);
    bus(1'b1, 1'b1, 1'b1);
    cur_req = "R2"; unlock();
    cur_req = "R1"; xfer_read();

    // write all registers; register 4 bit 4 cleared to enable the pin
    cur_req = "R7"; unlock();
    xfer_write(64'h8877_6620_4433_2211);
    cur_req = "R6"; unlock(); xfer_read();

    // key interleaved with idle and power-fail cycles
    cur_req = "R10";
    rd();
    for (int i = 0; i < 64; i++) begin
      if (i % 5 == 0) bus(1'b0, 1'b1, ~key_bit(i));
      if (i % 7 == 3) begin cur_req = "R9"; bus(1'b1, 1'b1, ~key_bit(i), 1'b1, 1'b1); cur_req = "R10"; end
      if (i % 11 == 4) begin cur_req = "R9"; bus(1'b1, 1'b0, 1'b0, 1'b1, 1'b1); cur_req = "R10"; end
      wr(key_bit(i));
    end
    for (int i = 0; i < 64; i++) begin
      if (i % 9 == 2) bus(1'b0, 1'b0, 1'b0);
      if (i % 13 == 6) begin cur_req = "R9"; bus(1'b1, 1'b0, 1'b0, 1'b1, 1'b1); cur_req = "R10"; end
      rd();
    end
    wr(1'b1); wr(1'b0);
    // key without a read after window closed
    for (int i = 0; i < 64; i++) wr(key_bit(i));
    wr(1'b0); rd();

    // mismatch freezes recognition
    cur_req = "R4";
    rd();
    for (int i = 0; i < 64; i++) wr((i == 10) ? ~key_bit(i) : key_bit(i));
    for (int i = 0; i < 64; i++) wr(key_bit(i));
    wr(1'b1);

    // read mid-key restarts
    cur_req = "R3";
    rd();
    for (int i = 0; i < 30; i++) wr(key_bit(i));
    rd();
    for (int i = 0; i < 64; i++) wr(key_bit(i));
    xfer_read();

    // pin abort after one full byte and four more bits
    cur_req = "R8";
    unlock();
    for (int i = 0; i < 12; i++) wr(~i[0]);
    bus(1'b0, 1'b0, 1'b0, 1'b0);
    wr(1'b1);
    unlock(); xfer_read();

    // group mixing reads and writes is discarded; register 4 bit 4 set
    cur_req = "R7";
    unlock();
    for (int i = 0; i < 8; i++) if (i[0]) rd(); else wr(1'b1);
    for (int i = 8; i < 64; i++) wr((i / 8 == 4) ? ((i % 8) == 4) : i[1]);
    // pin ignored while bit 4 is 1
    cur_req = "R8";
    unlock();
    for (int i = 0; i < 64; i++) bus(1'b1, 1'b0, 1'b0, i[2]);
    wr(1'b0);

    // power-fail inside the window
    cur_req = "R9";
    unlock();
    for (int i = 0; i < 64; i++) begin
      if (i % 6 == 1) bus(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
      rd();
    end
    cur_req = "R5";
    wr(1'b1); rd();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule